// File: doc/BRIEF.md
# One-Time Fuse Programming Sequencer

This block turns the current wiper code into a permanent setting by walking a small bank of one-time fuses in a fixed order. A single program request starts the walk. A dedicated test fuse is strobed first, then one fuse for each code bit, then the sensed data fuses are compared against the code, and last a lock fuse is strobed. Each strobe carries the index of its fuse. The sensed state of every fuse comes back on a per-fuse input, so a model outside the block decides whether a strobe actually blew its fuse.

The outcome is a 2-bit status that never changes again until the next reset, together with a lock flag. While the part is unlocked, the wiper output follows the code register that lives outside this block. Once the part is locked, the wiper output comes from a latch that is loaded from the data fuses, both at the end of a successful programming run and at every start-up on which the lock fuse senses as blown. The block accepts only one programming attempt. A request that arrives while the status is anything other than ready has no effect.

Top module: `otp_fuse_sequencer`

## Requirements
- R1: After reset with no fuse sensed as blown, the block reports status 00, lock low, busy low and no strobe, and the wiper output follows the code input.
- R2: The status codes are: 00 ready to program, 01 the test fuse did not blow, 10 fatal error (data mismatch, or an earlier attempt that never locked), 11 programmed and locked.
- R3: An accepted request raises busy on the next cycle. Busy stays high until a final status is set and falls in the same cycle that status appears. A successful run keeps busy high for 8*BLOW_CYCLES+2 cycles. The code input must not change while busy is high.
- R4: The first strobe always targets index 0, the test fuse, and lasts BLOW_CYCLES cycles. If the test fuse does not sense as blown one cycle later, the status becomes 01 and no further strobe follows.
- R5: After a good test fuse, indices 1 to CODE_W (code bits D0 upward) are visited in ascending order, one step of BLOW_CYCLES cycles each. The strobe is high during a step only when the matching code bit is 1.
- R6: After the data steps, the sensed data fuses are compared with the code input. A mismatch sets status 10 and no lock strobe is issued.
- R7: On a match, the lock fuse at index CODE_W+1 is strobed for BLOW_CYCLES cycles, after which the status becomes 11 and the lock flag rises.
- R8: While locked, the wiper output equals the stored fuse value, and changes on the code input have no effect on it.
- R9: A request made while the status is not 00 raises neither busy nor the strobe and leaves the status unchanged.
- R10: In the first cycle after reset, a lock fuse sensed as blown gives status 11, lock high and the wiper equal to the sensed data fuses, with no strobe. A test fuse sensed as blown without the lock fuse gives status 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencing clock |
| rst | input | 1 | Synchronous active-high reset (start-up) |
| prog_req_i | input | 1 | Request to make the current code permanent |
| code_i | input | CODE_W | Code from the wiper register |
| fuse_sense_i | input | CODE_W+2 | Sensed fuse states: bit 0 test fuse, bits 1..CODE_W data D0..D(CODE_W-1), top bit lock fuse |
| blow_o | output | 1 | Fuse blow strobe |
| blow_idx_o | output | clog2(CODE_W+2) | Index of the fuse being strobed |
| status_o | output | 2 | Validation status code |
| locked_o | output | 1 | Permanent setting in force |
| busy_o | output | 1 | Programming run in progress |
| wiper_o | output | CODE_W | Wiper code driven to the resistor decoder |

## Verification
The assertions assume that the surrounding interface freezes the code input for as long as busy is high. They also assume that the fuse sense inputs only move from unblown to blown between resets. The bench holds the code steady through every run. Its fuse model only ever sets sense bits, and it does so on the falling edge after a strobe cycle, with fault masks that keep chosen fuses from blowing. Fuse patterns that stand for earlier attempts are loaded only while reset is held, so the start-up decode always sees them stable.

// File: rtl/otp_seq_pkg.sv
`timescale 1ns/1ps
package otp_seq_pkg;

    typedef enum logic [1:0] {
        ST_READY     = 2'b00,
        ST_TEST_FAIL = 2'b01,
        ST_MISMATCH  = 2'b10,
        ST_LOCKED    = 2'b11
    } otp_status_e;

    typedef enum logic [2:0] {
        S_BOOT,
        S_IDLE,
        S_BLOW,
        S_TEST_CHK,
        S_COMPARE,
        S_DONE
    } seq_state_e;

    // A final status is any code other than ready; it is never left before reset.
    function automatic logic is_final(input otp_status_e st);
        return st != ST_READY;
    endfunction

endpackage

// File: rtl/otp_blow_timer.sv
`timescale 1ns/1ps
module otp_blow_timer #(
    parameter int BLOW_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic step_done
);
    localparam int CNT_W = (BLOW_CYCLES > 1) ? $clog2(BLOW_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BLOW_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    assign step_done = run && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run || step_done) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R5: a step never runs past its programmed length
    p_step_len_r5: assert property (@(posedge clk) disable iff (rst)
        run && !step_done |=> (cnt_q != '0) || !run);

endmodule

// File: rtl/otp_wiper_select.sv
`timescale 1ns/1ps
module otp_wiper_select #(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [CODE_W-1:0] fuse_data,
    input  logic              use_fuse,
    input  logic [CODE_W-1:0] reg_code,
    output logic [CODE_W-1:0] wiper
);
    logic [CODE_W-1:0] latch_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
        end else if (load) begin
            latch_q <= fuse_data;
        end
    end

    assign wiper = use_fuse ? latch_q : reg_code;

endmodule

// File: rtl/otp_fuse_sequencer.sv
`timescale 1ns/1ps
module otp_fuse_sequencer
    import otp_seq_pkg::*;
#(
    parameter int CODE_W      = 6,
    parameter int BLOW_CYCLES = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        prog_req_i,
    input  logic [CODE_W-1:0]           code_i,
    input  logic [CODE_W+1:0]           fuse_sense_i,
    output logic                        blow_o,
    output logic [$clog2(CODE_W+2)-1:0] blow_idx_o,
    output logic [1:0]                  status_o,
    output logic                        locked_o,
    output logic                        busy_o,
    output logic [CODE_W-1:0]           wiper_o
);
    localparam int NFUSE = CODE_W + 2;
    localparam int IDX_W = $clog2(NFUSE);
    localparam logic [IDX_W-1:0] IDX_TEST       = '0;
    localparam logic [IDX_W-1:0] IDX_FIRST_DATA = IDX_W'(1);
    localparam logic [IDX_W-1:0] IDX_LAST_DATA  = IDX_W'(CODE_W);
    localparam logic [IDX_W-1:0] IDX_LOCK       = IDX_W'(NFUSE - 1);

    seq_state_e        state_q;
    otp_status_e       status_q;
    logic [IDX_W-1:0]  idx_q;
    logic              locked_q;
    logic              step_done;
    logic              data_match;
    logic              latch_load;
    logic [NFUSE-1:0]  blow_wanted;
    logic [CODE_W-1:0] sensed_data;

    // Test and lock fuses are always strobed; data fuses only for ones.
    assign blow_wanted = {1'b1, code_i, 1'b1};
    assign sensed_data = fuse_sense_i[CODE_W:1];
    assign data_match  = (sensed_data == code_i);
    assign latch_load  = ((state_q == S_BOOT) && fuse_sense_i[IDX_LOCK]) ||
                         ((state_q == S_COMPARE) && data_match);

    assign blow_o     = (state_q == S_BLOW) && blow_wanted[idx_q];
    assign blow_idx_o = idx_q;
    assign status_o   = status_q;
    assign locked_o   = locked_q;
    assign busy_o     = (state_q == S_BLOW) || (state_q == S_TEST_CHK) ||
                        (state_q == S_COMPARE);

    otp_blow_timer #(.BLOW_CYCLES(BLOW_CYCLES)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .run       (state_q == S_BLOW),
        .step_done (step_done)
    );

    otp_wiper_select #(.CODE_W(CODE_W)) u_wiper (
        .clk       (clk),
        .rst       (rst),
        .load      (latch_load),
        .fuse_data (sensed_data),
        .use_fuse  (locked_q),
        .reg_code  (code_i),
        .wiper     (wiper_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= S_BOOT;
            status_q <= ST_READY;
            idx_q    <= IDX_TEST;
            locked_q <= 1'b0;
        end else begin
            case (state_q)
                S_BOOT: begin
                    if (fuse_sense_i[IDX_LOCK]) begin
                        status_q <= ST_LOCKED;
                        locked_q <= 1'b1;
                        state_q  <= S_DONE;
                    end else if (fuse_sense_i[IDX_TEST]) begin
                        status_q <= ST_MISMATCH;
                        state_q  <= S_DONE;
                    end else begin
                        state_q  <= S_IDLE;
                    end
                end
                S_IDLE: begin
                    if (prog_req_i && !is_final(status_q)) begin
                        idx_q   <= IDX_TEST;
                        state_q <= S_BLOW;
                    end
                end
                S_BLOW: begin
                    if (step_done) begin
                        if (idx_q == IDX_TEST) begin
                            state_q <= S_TEST_CHK;
                        end else if (idx_q == IDX_LOCK) begin
                            status_q <= ST_LOCKED;
                            locked_q <= 1'b1;
                            state_q  <= S_DONE;
                        end else if (idx_q == IDX_LAST_DATA) begin
                            state_q <= S_COMPARE;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                S_TEST_CHK: begin
                    if (fuse_sense_i[IDX_TEST]) begin
                        idx_q   <= IDX_FIRST_DATA;
                        state_q <= S_BLOW;
                    end else begin
                        status_q <= ST_TEST_FAIL;
                        state_q  <= S_DONE;
                    end
                end
                S_COMPARE: begin
                    if (data_match) begin
                        idx_q   <= IDX_LOCK;
                        state_q <= S_BLOW;
                    end else begin
                        status_q <= ST_MISMATCH;
                        state_q  <= S_DONE;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    // R4: no strobe outside a programming run
    p_strobe_in_run_r4: assert property (@(posedge clk) disable iff (rst)
        blow_o |-> busy_o);

    // R2: status stays at ready for the whole of a run
    p_ready_while_busy_r2: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> status_o == 2'b00);

    // R3: the wiper register is frozen during a run
    p_code_frozen_r3: assert property (@(posedge clk) disable iff (rst)
        busy_o && $past(busy_o) |-> $stable(code_i));

    // R7: lock only rises together with the success code
    p_lock_with_success_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(locked_o) |-> status_o == 2'b11);

    // R8: lock is sticky and the wiper holds while locked
    p_lock_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        locked_o |=> locked_o && status_o == 2'b11);
    p_wiper_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        locked_o && $past(locked_o) |-> $stable(wiper_o));

    // R9: a final status never restarts a run or changes
    p_no_retry_r9: assert property (@(posedge clk) disable iff (rst)
        is_final(otp_status_e'(status_o)) && !busy_o |=> !busy_o && $stable(status_o));

endmodule

// File: tb/otp_fuse_sequencer_tb.sv
`timescale 1ns/1ps
module otp_fuse_sequencer_tb_top;
    localparam int CW = 6;
    localparam int BC = 4;
    localparam int NF = CW + 2;
    localparam int IW = $clog2(NF);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          prog_req = 1'b0;
    logic [CW-1:0] code = 6'h20;
    logic [NF-1:0] fuse_q = '0;
    logic [NF-1:0] stuck_mask = '0;
    logic          blow;
    logic [IW-1:0] blow_idx;
    logic [1:0]    status;
    logic          locked;
    logic          busy;
    logic [CW-1:0] wiper;

    int n_vec = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    otp_fuse_sequencer #(.CODE_W(CW), .BLOW_CYCLES(BC)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .prog_req_i   (prog_req),
        .code_i       (code),
        .fuse_sense_i (fuse_q),
        .blow_o       (blow),
        .blow_idx_o   (blow_idx),
        .status_o     (status),
        .locked_o     (locked),
        .busy_o       (busy),
        .wiper_o      (wiper)
    );

    // Fuse model: a strobed fuse senses as blown unless masked as faulty.
    always @(negedge clk) begin
        if (blow && !stuck_mask[blow_idx]) fuse_q[blow_idx] <= 1'b1;
    end

    typedef struct {
        string         req;
        logic [1:0]    st;
        logic          lk;
        logic [CW-1:0] wp;
        int            blows;
        int            busy_n;
        int            last_idx;
    } exp_t;

    exp_t sb[$];

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: measures each run and compares it with the scoreboard head.
    int blows = 0, busy_n = 0, last_idx = 0, first_idx = 0, blow_total = 0;
    bit order_bad = 1'b0;
    logic busy_prev = 1'b0;

    always @(negedge clk) begin
        if (rst) begin
            blows = 0; busy_n = 0; order_bad = 1'b0; busy_prev = 1'b0;
        end else begin
            if (blow) begin
                if (blows == 0) first_idx = int'(blow_idx);
                else if (int'(blow_idx) < last_idx) order_bad = 1'b1;
                last_idx = int'(blow_idx);
                blows++;
                blow_total++;
            end
            if (busy) busy_n++;
            if (busy_prev && !busy) begin
                if (sb.size() == 0) begin
                    chk("R3", "unexpected run end", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(e.req, "status", int'(status), int'(e.st));
                    chk(e.req, "locked", int'(locked), int'(e.lk));
                    chk(e.req, "wiper", int'(wiper), int'(e.wp));
                    chk("R5", "strobe cycles", blows, e.blows);
                    chk("R3", "busy cycles", busy_n, e.busy_n);
                    chk("R4", "first strobe index", first_idx, 0);
                    chk("R5", "last strobe index", last_idx, e.last_idx);
                    chk("R5", "ascending order", int'(order_bad), 0);
                end
                blows = 0; busy_n = 0; order_bad = 1'b0;
            end
            busy_prev = busy;
        end
    end

    task automatic power_up(input logic [NF-1:0] preset);
        @(negedge clk);
        rst = 1'b1;
        stuck_mask = '0;
        fuse_q = preset;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic program_run(input logic [CW-1:0] c, input exp_t e);
        code = c;
        @(negedge clk);
        sb.push_back(e);
        prog_req = 1'b1;
        @(negedge clk);
        prog_req = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic try_ignored(input string req);
        int t0;
        logic [1:0] st0;
        bit saw_busy;
        t0 = blow_total;
        st0 = status;
        saw_busy = 1'b0;
        prog_req = 1'b1;
        @(negedge clk);
        prog_req = 1'b0;
        for (int i = 0; i < 3 * BC; i++) begin
            @(negedge clk);
            if (busy) saw_busy = 1'b1;
        end
        chk(req, "busy after ignored request", int'(saw_busy), 0);
        chk(req, "strobes after ignored request", blow_total - t0, 0);
        chk(req, "status after ignored request", int'(status), int'(st0));
    endtask

    function automatic exp_t mk(input string r, input logic [1:0] s, input logic l,
                                input logic [CW-1:0] w, input int b, input int bn, input int li);
        exp_t e;
        e.req = r; e.st = s; e.lk = l; e.wp = w; e.blows = b; e.busy_n = bn; e.last_idx = li;
        return e;
    endfunction

    initial begin
        int t0;
        // Reset state, fresh part
        power_up('0);
        chk("R1", "status", int'(status), 0);
        chk("R1", "locked", int'(locked), 0);
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "strobe", int'(blow), 0);
        chk("R1", "wiper follows code", int'(wiper), 'h20);
        code = 6'h11;
        @(negedge clk);
        chk("R1", "wiper follows new code", int'(wiper), 'h11);

        // Successful run, code 2D (four ones)
        program_run(6'h2D, mk("R7", 2'b11, 1'b1, 6'h2D, 6 * BC, 8 * BC + 2, NF - 1));
        chk("R2", "success code", int'(status), 3);
        code = 6'h05;
        @(negedge clk);
        chk("R8", "wiper ignores code when locked", int'(wiper), 'h2D);
        try_ignored("R9");

        // Start-up with the lock fuse kept
        t0 = blow_total;
        power_up(fuse_q);
        chk("R10", "status after start-up", int'(status), 3);
        chk("R10", "locked after start-up", int'(locked), 1);
        chk("R10", "wiper from fuses", int'(wiper), 'h2D);
        chk("R10", "no strobe at start-up", blow_total - t0, 0);

        // Test fuse refuses to blow
        power_up('0);
        stuck_mask = 8'h01;
        program_run(6'h3F, mk("R4", 2'b01, 1'b0, 6'h3F, BC, BC + 1, 0));
        chk("R2", "test failure code", int'(status), 1);
        try_ignored("R9");

        // Data fuse D3 refuses to blow
        power_up('0);
        stuck_mask = 8'h10;
        program_run(6'h3F, mk("R6", 2'b10, 1'b0, 6'h3F, 7 * BC, 7 * BC + 2, CW));
        chk("R6", "lock fuse untouched", int'(fuse_q[NF-1]), 0);
        power_up(fuse_q);
        chk("R10", "earlier failed attempt", int'(status), 2);
        try_ignored("R9");

        // All-zero code: only test and lock strobes
        power_up('0);
        program_run(6'h00, mk("R5", 2'b11, 1'b1, 6'h00, 2 * BC, 8 * BC + 2, NF - 1));
        code = 6'h3F;
        @(negedge clk);
        chk("R8", "zero code stays", int'(wiper), 0);

        // All-ones code
        power_up('0);
        program_run(6'h3F, mk("R7", 2'b11, 1'b1, 6'h3F, 8 * BC, 8 * BC + 2, NF - 1));

        // Pre-blown pattern: lock + data 15
        power_up({1'b1, 6'h15, 1'b1});
        chk("R10", "preset status", int'(status), 3);
        chk("R10", "preset wiper", int'(wiper), 'h15);

        // Fresh part again
        power_up('0);
        chk("R1", "fresh status", int'(status), 0);
        chk("R3", "scoreboard drained", sb.size(), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL R3 watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule